// File: doc/BRIEF.md
# Multi-Context Folding Logic Element

This block is a single logic element whose 4-input look-up table changes function at run time. A small store holds up to sixteen context words. A sequencer copies the active word into a working register that drives the LUT. It moves on to the next word after a programmable number of evaluations, so a multi-level netlist can be folded onto this one element. Every enabled cycle, the LUT result is captured in a flip-flop. Later contexts can route that captured value back in place of any LUT input, so a folded chain of depth d gives its result after d evaluation cycles.

Contexts are loaded while sequencing is stopped. Software programs three things: the last used context index, the number of evaluations spent in each context, and the context words. It then raises the enable. A one-cycle completion pulse marks the end of each full pass through the used contexts.

Top module: `fold_lut_cell`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the element clears the context index, the completion pulse and the captured flip-flop value to 0.
- R2: A context word is 21 bits. Bits [15:0] are the truth table, with bit k giving the LUT result for input address k. Bits [19:16] select the source of each input. Bit 20 is the output mode.
- R3: LUT input i is `ext_in[i]` when select bit 16+i is 0, and the captured flip-flop value when it is 1. The LUT result is the truth-table bit addressed by the four inputs, with input i as address bit i.
- R4: When bit 20 of the active word is 1, `lut_out` shows the flip-flop value. When it is 0, `lut_out` shows the combinational LUT result of the current cycle.
- R5: In every enabled cycle the flip-flop captures the LUT result. While `en` is low it is cleared to 0.
- R6: With `eval_m1` = p-1, each context stays active for exactly p consecutive enabled cycles before the next one takes over.
- R7: After the context at index `ctx_last` (or any higher index) finishes, the sequence wraps to context 0. Otherwise it advances by one, so `ctx_last`+1 contexts are in use.
- R8: `done` is high for the single cycle that follows the final evaluation of the last used context, and low at all other times.
- R9: A context write takes effect only when `en` is low. A write attempted while `en` is high leaves the stored words unchanged.
- R10: A write whose index is 16 or above (bit 4 of `cfg_idx` set) changes no stored word.
- R11: While `en` is low, the context index returns to 0 and word 0 is loaded into the working register on each clock. The first enabled cycle therefore evaluates context 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Sequencing enable |
| cfg_we | input | 1 | Context write strobe |
| cfg_idx | input | 5 | Context write index (16 and above is out of range) |
| cfg_word | input | 21 | Context word to write |
| ctx_last | input | 4 | Index of the last used context |
| eval_m1 | input | 4 | Evaluations per context minus one |
| ext_in | input | 4 | External LUT inputs |
| lut_out | output | 1 | Element output (registered or combinational per context) |
| ctx_cur | output | 4 | Index of the active context |
| done | output | 1 | One-cycle pulse at the end of a full pass |

## Verification
The assertions check the sequencer on every cycle. A context holds while its evaluation count is short of p. It steps by exactly one below the last index. It returns to 0 whenever sequencing is off. The completion pulse appears only after an enabled cycle, lands on context 0 and lasts one cycle. Only the bench scenarios can show the data path: truth-table addressing, feedback selection, output mode, and the way ignored writes leave the stored words intact. The bench shows these by sweeping input patterns across every context, by sweeping fold levels against sequence lengths, and by reading the stored words back through normal sequencing.

// File: rtl/fold_lut_cell.sv
module fold_lut_cell #(
  parameter int CTX    = 16,
  parameter int LUT_IN = 4,
  parameter int FOLDW  = 4,
  localparam int TTW   = 1 << LUT_IN,
  localparam int CW    = TTW + LUT_IN + 1,
  localparam int IDXW  = $clog2(CTX)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            cfg_we,
  input  logic [IDXW:0]   cfg_idx,
  input  logic [CW-1:0]   cfg_word,
  input  logic [IDXW-1:0] ctx_last,
  input  logic [FOLDW-1:0] eval_m1,
  input  logic [LUT_IN-1:0] ext_in,
  output logic            lut_out,
  output logic [IDXW-1:0] ctx_cur,
  output logic            done
);

  logic [CW-1:0]     store [CTX];
  logic [CW-1:0]     work_q;
  logic [IDXW-1:0]   ctx_q;
  logic [FOLDW-1:0]  eval_q;
  logic              ff_q;
  logic              done_q;
  logic [LUT_IN-1:0] addr;

  wire [TTW-1:0]    tt       = work_q[TTW-1:0];
  wire [LUT_IN-1:0] sel      = work_q[TTW +: LUT_IN];
  wire              reg_mode = work_q[CW-1];
  wire              lut_val  = tt[addr];
  wire              step_end = (eval_q == eval_m1);
  wire              seq_end  = (ctx_q >= ctx_last);
  wire [IDXW-1:0]   ctx_nxt  = seq_end ? '0 : ctx_q + 1'b1;
  wire              wr_ok    = cfg_we && !en && !cfg_idx[IDXW];

  for (genvar i = 0; i < LUT_IN; i++) begin : g_insel
    assign addr[i] = sel[i] ? ff_q : ext_in[i];
  end

  always_ff @(posedge clk) begin
    if (wr_ok) store[cfg_idx[IDXW-1:0]] <= cfg_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_q  <= '0;
      eval_q <= '0;
      ff_q   <= 1'b0;
      done_q <= 1'b0;
      work_q <= '0;
    end else if (!en) begin
      ctx_q  <= '0;
      eval_q <= '0;
      ff_q   <= 1'b0;
      done_q <= 1'b0;
      work_q <= store[0];
    end else begin
      ff_q <= lut_val;
      if (step_end) begin
        eval_q <= '0;
        ctx_q  <= ctx_nxt;
        work_q <= store[ctx_nxt];
        done_q <= seq_end;
      end else begin
        eval_q <= eval_q + 1'b1;
        done_q <= 1'b0;
      end
    end
  end

  assign lut_out = reg_mode ? ff_q : lut_val;
  assign ctx_cur = ctx_q;
  assign done    = done_q;

endmodule

module fold_lut_cell_chk #(
  parameter int IDXW  = 4,
  parameter int FOLDW = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            en,
  input logic            done,
  input logic [IDXW-1:0] ctx_cur,
  input logic [IDXW-1:0] ctx_last,
  input logic [FOLDW-1:0] eval_cnt,
  input logic [FOLDW-1:0] eval_m1
);

  AST_IDLE_CTX_ZERO: assert property (@(posedge clk) disable iff (rst)
    !en |=> ctx_cur == '0); // R11

  AST_HOLD_MID_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && eval_cnt != eval_m1) |=> $stable(ctx_cur)); // R6

  AST_CTX_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (en && eval_cnt == eval_m1 && ctx_cur < ctx_last) |=> ctx_cur == $past(ctx_cur) + 1'b1); // R7

  AST_DONE_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    done |-> ctx_cur == '0); // R7

  AST_DONE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(en)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (done && !(ctx_last == '0 && eval_m1 == '0)) |=> !done); // R8

endmodule

bind fold_lut_cell fold_lut_cell_chk #(.IDXW(IDXW), .FOLDW(FOLDW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .done     (done),
  .ctx_cur  (ctx_cur),
  .ctx_last (ctx_last),
  .eval_cnt (eval_q),
  .eval_m1  (eval_m1)
);

// File: tb/fold_lut_cell_bench.sv
`timescale 1ns/1ps
module fold_lut_cell_bench;

  logic        clk = 1'b0;
  logic        rst, en, cfg_we;
  logic [4:0]  cfg_idx;
  logic [20:0] cfg_word;
  logic [3:0]  ctx_last, eval_m1, ext_in;
  logic        lut_out, done;
  logic [3:0]  ctx_cur;

  int errors = 0;
  int checks = 0;
  bit chk_out = 1'b0;

  logic [20:0] m_mem [16];
  logic [20:0] m_work;
  logic [3:0]  m_ctx, m_eval;
  logic        m_ff, m_done;

  always #4 clk = ~clk;

  fold_lut_cell u_fold_lut_cell (
    .clk(clk), .rst(rst), .en(en), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_word(cfg_word), .ctx_last(ctx_last), .eval_m1(eval_m1),
    .ext_in(ext_in), .lut_out(lut_out), .ctx_cur(ctx_cur), .done(done)
  );

  function automatic logic [20:0] gen(int i, int s);
    return {1'((i + s) & 1), 4'(i * 3 + s), 16'(((i + 1) * 40503) ^ (s * 7919))};
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic tick(string tag);
    logic [3:0] a;
    logic lv, eo;
    #1;
    for (int i = 0; i < 4; i++) a[i] = m_work[16+i] ? m_ff : ext_in[i];
    lv = m_work[a];
    eo = m_work[20] ? m_ff : lv;
    chk("R6/R7", "ctx_cur", int'(ctx_cur), int'(m_ctx));
    chk("R8", "done", int'(done), int'(m_done));
    if (chk_out) chk(tag, "lut_out", int'(lut_out), int'(eo));
    if (rst) begin
      m_ctx = 0; m_eval = 0; m_ff = 0; m_done = 0; m_work = '0;
    end else if (!en) begin
      m_ctx = 0; m_eval = 0; m_ff = 0; m_done = 0; m_work = m_mem[0];
      if (cfg_we && !cfg_idx[4]) m_mem[cfg_idx[3:0]] = cfg_word;
    end else begin
      m_ff = lv;
      if (m_eval == eval_m1) begin
        m_eval = 0;
        m_done = (m_ctx >= ctx_last);
        m_ctx  = (m_ctx >= ctx_last) ? 4'd0 : m_ctx + 4'd1;
        m_work = m_mem[m_ctx];
      end else begin
        m_eval = m_eval + 4'd1;
        m_done = 0;
      end
    end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: all requirements actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst = 1; en = 0; cfg_we = 0; cfg_idx = '0; cfg_word = '0;
    ctx_last = 4'd15; eval_m1 = 4'd0; ext_in = '0;
    for (int i = 0; i < 16; i++) m_mem[i] = '0;
    m_work = '0; m_ctx = 0; m_eval = 0; m_ff = 0; m_done = 0;
    @(negedge clk);
    tick("R1");
    tick("R1");
    rst = 0;

    // R2: load all contexts
    for (int i = 0; i < 16; i++) begin
      cfg_we = 1; cfg_idx = 5'(i); cfg_word = gen(i, 1); tick("R2");
    end
    // R10: out-of-range writes
    for (int i = 16; i < 32; i++) begin
      cfg_we = 1; cfg_idx = 5'(i); cfg_word = gen(i, 9); tick("R10");
    end
    cfg_we = 0;
    tick("R11");
    chk_out = 1'b1;
    tick("R11");

    // R3: level-1 sweep of input patterns over all contexts
    en = 1;
    for (int pass = 0; pass < 16; pass++)
      for (int k = 0; k < 16; k++) begin
        ext_in = 4'(pass ^ (k * 5)); tick("R3");
      end

    // R9: writes while enabled are ignored
    for (int k = 0; k < 16; k++) begin
      cfg_we = 1; cfg_idx = 5'(k); cfg_word = gen(k, 5); ext_in = 4'(k); tick("R9");
    end
    cfg_we = 0; en = 0; tick("R11");
    en = 1;
    for (int k = 0; k < 32; k++) begin
      ext_in = 4'(k * 7); tick("R9");
    end

    // R6, R7, R8: fold level against sequence length
    for (int p = 0; p < 4; p++)
      foreach (ctx_last[b]) begin
        en = 0; eval_m1 = 4'(p);
        ctx_last = (b == 0) ? 4'd0 : (b == 1) ? 4'd2 : (b == 2) ? 4'd5 : 4'd15;
        tick("R11"); tick("R11");
        en = 1;
        for (int c = 0; c < (int'(ctx_last) + 1) * (p + 1) * 2 + 2; c++) begin
          ext_in = 4'(c * 3 + p); tick("R6");
        end
      end

    // R4, R5: directed folded chain with feedback
    en = 0; eval_m1 = 4'd0; ctx_last = 4'd2;
    cfg_we = 1; cfg_idx = 5'd0; cfg_word = {1'b0, 4'b0000, 16'h8000}; tick("R5");
    cfg_idx = 5'd1; cfg_word = {1'b0, 4'b0001, 16'h6666}; tick("R5");
    cfg_idx = 5'd2; cfg_word = {1'b1, 4'b0001, 16'hAAAA}; tick("R4");
    cfg_we = 0; tick("R11"); tick("R11");
    en = 1;
    for (int r = 0; r < 16; r++) begin
      ext_in = 4'(r); tick("R5"); tick("R5"); tick("R4");
    end
    ext_in = 4'hF; tick("R5");
    en = 0; tick("R5");
    tick("R5");
    en = 1; tick("R11"); tick("R4"); tick("R4");

    // R4, R5: mixed feedback words with both output modes
    en = 0; ctx_last = 4'd15; eval_m1 = 4'd1;
    for (int i = 0; i < 16; i++) begin
      cfg_we = 1; cfg_idx = 5'(i); cfg_word = gen(i, 3); tick("R2");
    end
    cfg_we = 0; tick("R11"); tick("R11");
    en = 1;
    for (int c = 0; c < 96; c++) begin
      ext_in = 4'(c ^ (c >> 2)); tick("R4");
    end

    en = 0; tick("R11");
    summary();
    $finish;
  end

endmodule